// File: doc/BRIEF.md
# Committed Store Write-Back Queue

This block keeps the stores of a processor core in program order between allocation and the moment memory confirms each write. A store receives a slot at the tail of a circular queue. The queue returns that slot index, and address, size and data are written into the slot later. A commit request carrying a sequence number releases every older store for write-back. A write-back pointer then presents the released stores to memory one at a time, in order.

A slot is returned to the free pool only after memory acknowledges its write, not at commit. Acknowledgements may arrive out of order, and the head pointer steps forward one slot per cycle across the completed slots at the front. A squash removes the uncommitted stores that are younger than a given sequence number. A refused write is held, and it is offered again once memory is ready. One slot is kept as a sentinel, so the queue reports full one entry short of its physical depth. Sequence numbers are plain unsigned values and are assumed not to wrap while stores are in flight.

Top module: `store_commit_queue`

## Requirements
- R1: After reset, count and pend_cnt are 0, and full and wr_req are low.
- R2: An accepted allocate writes its sequence number into the slot shown on alloc_idx. It then raises count by one and advances alloc_idx by one, modulo DEPTH. A fill writes address, size and data into slot fill_idx.
- R3: A commit with sequence number C marks every valid, uncommitted store whose sequence number is below C as committed. pend_cnt rises by the number of stores marked.
- R4: wr_req is high only when the slot at the write-back pointer is committed, is not yet completed and the port is not held. wr_idx, wr_addr, wr_size and wr_data show that slot. Stores go out in allocation order, one per cycle in which mem_rdy is high with wr_req.
- R5: A store whose write has been accepted stays counted in count until it is acknowledged.
- R6: If wr_req is high while mem_rdy is low, wr_req is low in the cycles that follow. It returns with the same store one cycle after mem_rdy is seen high.
- R7: ack_vld with ack_idx marks that slot completed and lowers pend_cnt by one. The head frees at most one completed slot per cycle, in order, starting one cycle after that slot's acknowledgement. An acknowledged slot behind an unacknowledged head is not freed.
- R8: A squash with sequence number S removes every uncommitted store whose sequence number is above S. Committed stores are kept. count becomes the number of survivors, and alloc_idx points just past the youngest survivor.
- R9: An allocate in the same cycle as a squash is ignored.
- R10: full is high when count is at least DEPTH-1. While full, an allocate is refused and changes neither count nor alloc_idx. count never exceeds DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation will take |
| fill_vld | input | 1 | Write address, size and data into a slot |
| fill_idx | input | log2(DEPTH) | Slot to fill |
| fill_addr | input | ADDR_W | Store address |
| fill_size | input | SIZE_W | Store size code |
| fill_data | input | DATA_W | Store data |
| cmt_vld | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Stores older than this number are committed |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Uncommitted stores younger than this number are removed |
| mem_rdy | input | 1 | Memory accepts a write this cycle |
| ack_vld | input | 1 | Memory confirms a write |
| ack_idx | input | log2(DEPTH) | Slot whose write is confirmed |
| wr_req | output | 1 | Write request to memory |
| wr_idx | output | log2(DEPTH) | Slot of the presented write |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | SIZE_W | Write size code |
| wr_data | output | DATA_W | Write data |
| full | output | 1 | Queue cannot take another store |
| count | output | log2(DEPTH)+1 | Stores held |
| pend_cnt | output | log2(DEPTH)+1 | Committed stores not yet acknowledged |

## Verification
The bench acknowledges the younger of two issued stores first. A head that frees on any completed slot would then shrink count early, and one that frees a whole run in one cycle would skip the one-per-cycle decrement. It refuses a write and then makes memory ready. A queue that keeps issuing while refused, or that advances past the held store, shows the wrong wr_addr. A squash whose boundary lies below two committed stores, with an allocate in the same cycle, catches a squash that drops committed entries or a tail that is not rebuilt from the survivors. Filling the queue across the index wrap checks the sentinel threshold and the refused allocate.

// File: rtl/sq_pkg.sv
package sq_pkg;
   typedef enum logic {
      WP_OPEN = 1'b0,
      WP_HELD = 1'b1
   } wp_state_e;
endpackage

// File: rtl/sq_popcnt.sv
module sq_popcnt #(
   parameter int N = 8,
   parameter int W = 4
) (
   input  logic [N-1:0] bits,
   output logic [W-1:0] total
);
   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) total = total + W'(bits[k]);
   end
endmodule

// File: rtl/sq_slot.sv
module sq_slot #(
   parameter int SEQ_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [SIZE_W-1:0] fill_size,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              cmt_vld,
   input  logic [SEQ_W-1:0]  cmt_seq,
   input  logic              sq_vld,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic              ack_en,
   input  logic              free_en,
   output logic              vld,
   output logic              cmt,
   output logic              done,
   output logic              keep,
   output logic              hit,
   output logic [ADDR_W-1:0] addr,
   output logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] data
);
   logic [SEQ_W-1:0] seq;

   // survives a squash this cycle (committed entries always do)
   assign keep = vld & (cmt | (seq <= sq_seq));
   // newly committed this cycle, only if not being squashed
   assign hit  = cmt_vld & vld & ~cmt & (seq < cmt_seq) & (~sq_vld | keep);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         cmt  <= 1'b0;
         done <= 1'b0;
         seq  <= '0;
      end else if (alloc_en) begin
         vld  <= 1'b1;
         cmt  <= 1'b0;
         done <= 1'b0;
         seq  <= alloc_seq;
      end else begin
         if (free_en || (sq_vld && !keep)) vld <= 1'b0;
         if (hit)    cmt  <= 1'b1;
         if (ack_en) done <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         addr <= fill_addr;
         size <= fill_size;
         data <= fill_data;
      end
   end
endmodule

// File: rtl/sq_wr_port.sv
module sq_wr_port
   import sq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic elig,
   input  logic mem_rdy,
   output logic wr_req,
   output logic accept
);
   wp_state_e st;

   assign wr_req = elig & (st == WP_OPEN);
   assign accept = wr_req & mem_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= WP_OPEN;
      else if (st == WP_OPEN && wr_req && !mem_rdy) st <= WP_HELD;
      else if (st == WP_HELD && mem_rdy) st <= WP_OPEN;
   end
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
   parameter int DEPTH  = 8,
   parameter int SEQ_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2,
   localparam int IW    = $clog2(DEPTH),
   localparam int CW    = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  logic [SEQ_W-1:0]  alloc_seq,
   output logic [IW-1:0]     alloc_idx,
   input  logic              fill_vld,
   input  logic [IW-1:0]     fill_idx,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [SIZE_W-1:0] fill_size,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              cmt_vld,
   input  logic [SEQ_W-1:0]  cmt_seq,
   input  logic              sq_vld,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic              mem_rdy,
   input  logic              ack_vld,
   input  logic [IW-1:0]     ack_idx,
   output logic              wr_req,
   output logic [IW-1:0]     wr_idx,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SIZE_W-1:0] wr_size,
   output logic [DATA_W-1:0] wr_data,
   output logic              full,
   output logic [CW-1:0]     count,
   output logic [CW-1:0]     pend_cnt
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
      $error("store_commit_queue: DEPTH must be a power of two, at least 4");
   if (SEQ_W < 2 || ADDR_W < 1 || DATA_W < 1 || SIZE_W < 1)
      $error("store_commit_queue: field widths too small");

   logic [IW-1:0] head, tail, wb;
   logic [DEPTH-1:0] s_vld, s_cmt, s_done, s_keep, s_hit;
   logic [ADDR_W-1:0] s_addr [DEPTH];
   logic [SIZE_W-1:0] s_size [DEPTH];
   logic [DATA_W-1:0] s_data [DEPTH];
   logic [CW-1:0] keep_n, hit_n;
   logic alloc_ok, free_hd, elig, accept;

   assign full     = count >= CW'(DEPTH - 1);
   assign alloc_ok = alloc_vld & ~full & ~sq_vld;
   assign free_hd  = s_vld[head] & s_done[head];
   assign elig     = s_vld[wb] & s_cmt[wb] & ~s_done[wb];
   assign alloc_idx = tail;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      sq_slot #(
         .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc_en (alloc_ok && (tail == IW'(g))),
         .alloc_seq(alloc_seq),
         .fill_en  (fill_vld && (fill_idx == IW'(g))),
         .fill_addr(fill_addr),
         .fill_size(fill_size),
         .fill_data(fill_data),
         .cmt_vld  (cmt_vld),
         .cmt_seq  (cmt_seq),
         .sq_vld   (sq_vld),
         .sq_seq   (sq_seq),
         .ack_en   (ack_vld && (ack_idx == IW'(g))),
         .free_en  (free_hd && (head == IW'(g))),
         .vld      (s_vld[g]),
         .cmt      (s_cmt[g]),
         .done     (s_done[g]),
         .keep     (s_keep[g]),
         .hit      (s_hit[g]),
         .addr     (s_addr[g]),
         .size     (s_size[g]),
         .data     (s_data[g])
      );
   end

   sq_popcnt #(.N(DEPTH), .W(CW)) u_keep_cnt (.bits(s_keep), .total(keep_n));
   sq_popcnt #(.N(DEPTH), .W(CW)) u_hit_cnt  (.bits(s_hit),  .total(hit_n));

   sq_wr_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig   (elig),
      .mem_rdy(mem_rdy),
      .wr_req (wr_req),
      .accept (accept)
   );

   assign wr_idx  = wb;
   assign wr_addr = s_addr[wb];
   assign wr_size = s_size[wb];
   assign wr_data = s_data[wb];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head     <= '0;
         tail     <= '0;
         wb       <= '0;
         count    <= '0;
         pend_cnt <= '0;
      end else begin
         head     <= head + IW'(free_hd);
         wb       <= wb + IW'(accept);
         pend_cnt <= pend_cnt + hit_n - CW'(ack_vld);
         if (sq_vld) begin
            tail  <= head + keep_n[IW-1:0];
            count <= keep_n - CW'(free_hd);
         end else begin
            tail  <= tail + IW'(alloc_ok);
            count <= count + CW'(alloc_ok) - CW'(free_hd);
         end
      end
   end
endmodule

// File: rtl/store_commit_queue_chk.sv
module store_commit_queue_chk #(
   parameter int DEPTH = 8,
   parameter int IW    = 3,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sq_vld,
   input logic          alloc_vld,
   input logic          mem_rdy,
   input logic          wr_req,
   input logic [IW-1:0] wr_idx,
   input logic          full,
   input logic [CW-1:0] count,
   input logic [CW-1:0] pend_cnt
);
   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH - 1);
   // R10
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && alloc_vld) |=> (count <= $past(count)));
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !mem_rdy) |=> (!wr_req && $stable(wr_idx)));
   // R4
   pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (pend_cnt != '0));
   // R9
   squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sq_vld |=> (count <= $past(count)));
   // R7
   one_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_vld |=> (int'(count) + 1 >= int'($past(count))));
endmodule

bind store_commit_queue store_commit_queue_chk #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sq_vld   (sq_vld),
   .alloc_vld(alloc_vld),
   .mem_rdy  (mem_rdy),
   .wr_req   (wr_req),
   .wr_idx   (wr_idx),
   .full     (full),
   .count    (count),
   .pend_cnt (pend_cnt)
);

// File: tb/test_store_commit_queue.sv
`timescale 1ns/1ps
module test_store_commit_queue;
   localparam int DEPTH = 8, SEQ_W = 8, ADDR_W = 16, DATA_W = 32, SIZE_W = 2;
   localparam int IW = $clog2(DEPTH), CW = IW + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_vld = 0, fill_vld = 0, cmt_vld = 0, sq_vld = 0, mem_rdy = 0, ack_vld = 0;
   logic [SEQ_W-1:0] alloc_seq = '0, cmt_seq = '0, sq_seq = '0;
   logic [IW-1:0] fill_idx = '0, ack_idx = '0, alloc_idx, wr_idx;
   logic [ADDR_W-1:0] fill_addr = '0, wr_addr;
   logic [SIZE_W-1:0] fill_size = '0, wr_size;
   logic [DATA_W-1:0] fill_data = '0, wr_data;
   logic wr_req, full;
   logic [CW-1:0] count, pend_cnt;
   int total = 0, bad = 0;
   bit over = 0;

   always #2.5 clk = ~clk;

   store_commit_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                        .DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_store_commit_queue (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_alloc(input int seq);
      alloc_vld = 1; alloc_seq = SEQ_W'(seq);
      tick();
      alloc_vld = 0;
   endtask

   task automatic do_fill(input int idx, input int a, input int d);
      fill_vld = 1; fill_idx = IW'(idx); fill_addr = ADDR_W'(a);
      fill_size = 2'd2; fill_data = DATA_W'(d);
      tick();
      fill_vld = 0;
   endtask

   task automatic do_ack(input int idx);
      ack_vld = 1; ack_idx = IW'(idx);
      tick();
      ack_vld = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; tick(); tick(); rst_n = 1;
      chk("R1 count", int'(count), 0);
      chk("R1 pend", int'(pend_cnt), 0);
      chk("R1 full", int'(full), 0);
      chk("R1 wr_req", int'(wr_req), 0);
   endtask

   task automatic t_alloc_fill();
      for (int i = 0; i < 3; i++) begin
         chk("R2 alloc_idx", int'(alloc_idx), i);
         do_alloc(10 + i);
      end
      for (int i = 0; i < 3; i++) do_fill(i, 'h100 + i, 'hA0 + i);
      chk("R2 count", int'(count), 3);
      chk("R4 no req before commit", int'(wr_req), 0);
   endtask

   task automatic t_commit_block();
      cmt_vld = 1; cmt_seq = 8'd12;
      tick();
      cmt_vld = 0;
      chk("R3 pend", int'(pend_cnt), 2);
      chk("R4 req", int'(wr_req), 1);
      chk("R4 addr", int'(wr_addr), 'h100);
      chk("R4 idx", int'(wr_idx), 0);
      tick();
      chk("R6 held", int'(wr_req), 0);
      tick();
      chk("R6 still held", int'(wr_req), 0);
      mem_rdy = 1;
      tick();
      chk("R6 retry req", int'(wr_req), 1);
      chk("R6 retry addr", int'(wr_addr), 'h100);
      tick();
      chk("R4 second addr", int'(wr_addr), 'h101);
      chk("R4 second data", int'(wr_data), 'hA1);
      chk("R4 second size", int'(wr_size), 2);
      tick();
      chk("R4 stop at uncommitted", int'(wr_req), 0);
      mem_rdy = 0;
      chk("R5 count after issue", int'(count), 3);
   endtask

   task automatic t_ack_order();
      do_ack(1);
      chk("R7 pend after ack", int'(pend_cnt), 1);
      chk("R7 no free behind head", int'(count), 3);
      tick();
      chk("R7 still no free", int'(count), 3);
      do_ack(0);
      chk("R7 pend zero", int'(pend_cnt), 0);
      chk("R5 count at ack edge", int'(count), 3);
      tick();
      chk("R7 free one", int'(count), 2);
      tick();
      chk("R7 free two", int'(count), 1);
   endtask

   task automatic t_squash();
      for (int i = 0; i < 3; i++) do_alloc(13 + i);
      chk("R2 count four", int'(count), 4);
      cmt_vld = 1; cmt_seq = 8'd14;
      tick();
      cmt_vld = 0;
      chk("R3 pend two", int'(pend_cnt), 2);
      sq_vld = 1; sq_seq = 8'd11; alloc_vld = 1; alloc_seq = 8'd99;
      tick();
      sq_vld = 0; alloc_vld = 0;
      chk("R8 committed survive", int'(count), 2);
      chk("R9 alloc ignored", int'(alloc_idx), 4);
      chk("R8 pend kept", int'(pend_cnt), 2);
      chk("R6 held after refusal", int'(wr_req), 0);
      mem_rdy = 1;
      tick(); tick(); tick();
      chk("R4 drained", int'(wr_req), 0);
      mem_rdy = 0;
      do_ack(2); do_ack(3); tick();
      chk("R7 all freed", int'(count), 0);
      chk("R7 pend cleared", int'(pend_cnt), 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH - 1; i++) do_alloc(30 + i);
      chk("R10 count full", int'(count), DEPTH - 1);
      chk("R10 full", int'(full), 1);
      do_alloc(40);
      chk("R10 refused count", int'(count), DEPTH - 1);
      chk("R10 refused idx", int'(alloc_idx), 3);
      sq_vld = 1; sq_seq = 8'd0;
      tick();
      sq_vld = 0;
      chk("R8 all removed", int'(count), 0);
      chk("R8 tail rebuilt", int'(alloc_idx), 4);
      chk("R10 not full", int'(full), 0);
   endtask

   initial begin
      t_reset();
      t_alloc_fill();
      t_commit_block();
      t_ack_order();
      t_squash();
      t_full();
      if (!over) begin
         over = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!over) begin
         over = 1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule